// File: doc/BRIEF.md
# DDR SDRAM Column Command Sequencer

This block turns single user requests into column-level read and write transactions on a DDR2/DDR3-style SDRAM command and data interface. It assumes the target row is already open. A user request carries the direction, a column address, a full burst of write data and one byte mask per beat. The request is taken through a valid/ready handshake. One cycle after acceptance the sequencer places one column command on the chip-select, row-strobe, column-strobe and write-enable lines. It then counts the programmed latency and steps through the burst, one data beat per controller clock.

Writes start driving data a write latency after the command. The write latency is one cycle less than the read latency. Each beat goes out with its own byte mask, and the data bus output enable is raised for exactly those beats. Reads sample the memory data input during the read-latency window and hand each beat back to the user, in order, with a valid strobe. A one-cycle done pulse marks the end of every burst. CAS latency (3 to 6) and burst length (4 or 8) come from configuration inputs. They are captured at the moment a request is accepted.

Top module: `col_cmd_seq`

## Requirements
- R1: While no command is being issued, the command lines sit at NOP: memCsN=1, memRasN=1, memCasN=1, memWeN=1. memCsN goes low for exactly one cycle, the cycle after a request is accepted (cycle 0 of the burst).
- R2: A read request issues memRasN=1, memCasN=0, memWeN=1 in cycle 0, with the request's column on memAddr (memAddr is 0 outside cycle 0).
- R3: A write request issues memRasN=1, memCasN=0, memWeN=0 in cycle 0, with the request's column on memAddr.
- R4: For a read with effective CAS latency CL, beat b is sampled from memDqIn during cycle CL+b. It is returned on rdData with rdValid=1 during cycle CL+b+1. rdValid is 0 in every other cycle.
- R5: For a write, beat b is driven on memDqOut with memDqOe=1 during cycle CL-1+b. memDqOe is 0 in every other cycle, including all of a read.
- R6: memDqm bit i = 1 masks byte i (not written). Write beat b carries reqWrMask[b*BYTES +: BYTES] in the same cycle as its data. memDqm is 0 on every beat of a read and whenever memDqOe is 0.
- R7: cfgBurst8=1 selects 8 beats and cfgBurst8=0 selects 4 beats. Write beat b takes its data from reqWrData[b*DATA_W +: DATA_W].
- R8: The effective CL is cfgCasLat limited to the range 3..6 (values below 3 act as 3, above 6 act as 6). CL and burst length are sampled only at acceptance, so changing the config inputs during a burst has no effect on that burst.
- R9: reqReady is 1 when idle and 0 from the cycle after acceptance until the last data beat has completed. reqValid during that time issues no command. reqReady returns to 1 in the cycle after the last beat.
- R10: done is a one-cycle pulse in the cycle after the last memory-side data beat (cycle CL+BL for reads, CL-1+BL for writes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCol | input | COL_W | Column address |
| reqWrData | input | MAX_BL*DATA_W | Write beats, beat b at bits b*DATA_W |
| reqWrMask | input | MAX_BL*DATA_W/8 | Byte masks per beat, 1 = masked |
| cfgCasLat | input | CL_W | CAS latency setting |
| cfgBurst8 | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memAddr | output | COL_W | Column address during command cycle |
| memDqOut | output | DATA_W | Write data to the pads |
| memDqOe | output | 1 | Data bus output enable |
| memDqm | output | DATA_W/8 | Byte masks to the pads |
| memDqIn | input | DATA_W | Read data from the pads |
| rdValid | output | 1 | Read beat valid |
| rdData | output | DATA_W | Read beat data |
| done | output | 1 | Burst complete pulse |

## Verification
Several rules are checked by the embedded properties on every cycle:
- chip select is a lone single-cycle pulse that follows an accepted handshake;
- the output enable is never raised while read data is being captured;
- done never lasts more than one cycle;
- the latched latency cannot move during a burst.

Other properties need expected values, so only the directed scenarios can show them:
- the exact cycle of each data beat relative to the command;
- the beat ordering and the per-beat mask pairing;
- the clamping of out-of-range CAS latency;
- immunity to configuration changes and extra requests during a burst.

// File: rtl/colseq_pkg.sv
package colseq_pkg;
  localparam int BEAT_W = 4;

  typedef struct packed {
    logic              load;
    logic              cmd;
    logic              isWrite;
    logic              drive;
    logic              capture;
    logic [BEAT_W-1:0] beatIdx;
  } seqStrobe_t;
endpackage

// File: rtl/colseq_ctrl.sv
module colseq_ctrl
  import colseq_pkg::*;
#(
  parameter int CL_W     = 3,
  parameter int CL_MIN   = 3,
  parameter int CL_MAX   = 6,
  parameter int BL_SHORT = 4,
  parameter int BL_LONG  = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [CL_W-1:0] cfgCasLat,
  input  logic            cfgBurst8,
  output logic            reqReady,
  output logic            done,
  output seqStrobe_t      strobe
);
  localparam int CNT_W = $clog2(CL_MAX + BL_LONG + 1);
  localparam int SUM_W = CNT_W + 1;

  typedef enum logic {ST_IDLE, ST_BUSY} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  latQ;
  logic [CNT_W-1:0]  blQ;
  logic              isWrQ;
  logic              doneQ;
  logic [CNT_W-1:0]  clampedCl;
  logic [SUM_W-1:0]  windowEnd;
  logic              inWindow;
  logic              lastBeat;
  logic              accept;
  logic [CNT_W-1:0]  beatOff;

  always_comb begin
    if (cfgCasLat < CL_W'(CL_MIN))      clampedCl = CNT_W'(CL_MIN);
    else if (cfgCasLat > CL_W'(CL_MAX)) clampedCl = CNT_W'(CL_MAX);
    else                                clampedCl = CNT_W'(cfgCasLat);
  end

  assign accept    = (state == ST_IDLE) && reqValid;
  assign windowEnd = SUM_W'(latQ) + SUM_W'(blQ);
  assign inWindow  = (state == ST_BUSY) && (cnt >= latQ) && (SUM_W'(cnt) < windowEnd);
  assign lastBeat  = (state == ST_BUSY) && (SUM_W'(cnt) == windowEnd - SUM_W'(1));
  assign beatOff   = cnt - latQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      latQ  <= '0;
      blQ   <= '0;
      isWrQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_BUSY;
            cnt   <= '0;
            isWrQ <= reqWrite;
            latQ  <= reqWrite ? clampedCl - CNT_W'(1) : clampedCl;
            blQ   <= cfgBurst8 ? CNT_W'(BL_LONG) : CNT_W'(BL_SHORT);
          end
        end
        default: begin
          cnt <= cnt + CNT_W'(1);
          if (lastBeat) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end
        end
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign done     = doneQ;

  always_comb begin
    strobe         = '0;
    strobe.load    = accept;
    strobe.cmd     = (state == ST_BUSY) && (cnt == '0);
    strobe.isWrite = isWrQ;
    strobe.drive   = inWindow && isWrQ;
    strobe.capture = inWindow && !isWrQ;
    strobe.beatIdx = BEAT_W'(beatOff);
  end

  // R9: an accepted request withdraws ready on the next cycle
  a_r9_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R1: the command follows the handshake by one cycle
  a_r1_cmd_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> strobe.cmd);

  // R10: done lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: latched latency holds while busy
  a_r8_lat_stable: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && !strobe.cmd) |-> $stable(latQ));
endmodule

// File: rtl/colseq_dp.sv
module colseq_dp
  import colseq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int DATA_W = 32,
  parameter int MAX_BL = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqStrobe_t                    strobe,
  input  logic [COL_W-1:0]              reqCol,
  input  logic [MAX_BL*DATA_W-1:0]      reqWrData,
  input  logic [MAX_BL*(DATA_W/8)-1:0]  reqWrMask,
  input  logic [DATA_W-1:0]             memDqIn,
  output logic                          memCsN,
  output logic                          memRasN,
  output logic                          memCasN,
  output logic                          memWeN,
  output logic [COL_W-1:0]              memAddr,
  output logic [DATA_W-1:0]             memDqOut,
  output logic                          memDqOe,
  output logic [DATA_W/8-1:0]           memDqm,
  output logic                          rdValid,
  output logic [DATA_W-1:0]             rdData
);
  localparam int BYTES = DATA_W / 8;
  localparam int IDX_W = (MAX_BL > 1) ? $clog2(MAX_BL) : 1;

  logic [COL_W-1:0]             colQ;
  logic [MAX_BL*DATA_W-1:0]     dataQ;
  logic [MAX_BL*BYTES-1:0]      maskQ;
  logic [DATA_W-1:0]            dataBeat [MAX_BL];
  logic [BYTES-1:0]             maskBeat [MAX_BL];
  logic [IDX_W-1:0]             idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colQ  <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (strobe.load) begin
      colQ  <= reqCol;
      dataQ <= reqWrData;
      maskQ <= reqWrMask;
    end
  end

  for (genvar b = 0; b < MAX_BL; b++) begin : g_beat
    assign dataBeat[b] = dataQ[b*DATA_W +: DATA_W];
    assign maskBeat[b] = maskQ[b*BYTES +: BYTES];
  end

  assign idx = strobe.beatIdx[IDX_W-1:0];

  assign memCsN   = !strobe.cmd;
  assign memRasN  = 1'b1;
  assign memCasN  = !strobe.cmd;
  assign memWeN   = !(strobe.cmd && strobe.isWrite);
  assign memAddr  = strobe.cmd ? colQ : '0;
  assign memDqOe  = strobe.drive;
  assign memDqOut = strobe.drive ? dataBeat[idx] : '0;
  assign memDqm   = strobe.drive ? maskBeat[idx] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= memDqIn;
    end
  end

  // R1: chip select is never low two cycles in a row
  a_r1_cs_single: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |=> memCsN);

  // R5: the bus is never driven while read data is captured
  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> !memDqOe);

  // R4: a returned read beat never coincides with a write beat
  a_r4_rd_not_during_write: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !memDqOe);
endmodule

// File: rtl/col_cmd_seq.sv
module col_cmd_seq
  import colseq_pkg::*;
#(
  parameter int COL_W    = 10,
  parameter int DATA_W   = 32,
  parameter int CL_W     = 3,
  parameter int CL_MIN   = 3,
  parameter int CL_MAX   = 6,
  parameter int BL_SHORT = 4,
  parameter int MAX_BL   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic                          reqWrite,
  input  logic [COL_W-1:0]              reqCol,
  input  logic [MAX_BL*DATA_W-1:0]      reqWrData,
  input  logic [MAX_BL*(DATA_W/8)-1:0]  reqWrMask,
  input  logic [CL_W-1:0]               cfgCasLat,
  input  logic                          cfgBurst8,
  output logic                          memCsN,
  output logic                          memRasN,
  output logic                          memCasN,
  output logic                          memWeN,
  output logic [COL_W-1:0]              memAddr,
  output logic [DATA_W-1:0]             memDqOut,
  output logic                          memDqOe,
  output logic [DATA_W/8-1:0]           memDqm,
  input  logic [DATA_W-1:0]             memDqIn,
  output logic                          rdValid,
  output logic [DATA_W-1:0]             rdData,
  output logic                          done
);
  seqStrobe_t strobe;

  colseq_ctrl #(
    .CL_W(CL_W), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX),
    .BL_SHORT(BL_SHORT), .BL_LONG(MAX_BL)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .cfgCasLat(cfgCasLat), .cfgBurst8(cfgBurst8),
    .reqReady(reqReady), .done(done), .strobe(strobe)
  );

  colseq_dp #(
    .COL_W(COL_W), .DATA_W(DATA_W), .MAX_BL(MAX_BL)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqCol(reqCol),
    .reqWrData(reqWrData), .reqWrMask(reqWrMask), .memDqIn(memDqIn),
    .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqm(memDqm),
    .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: tb/test_col_cmd_seq.sv
module test_col_cmd_seq;
  localparam int COL_W  = 10;
  localparam int DATA_W = 32;
  localparam int MAX_BL = 8;
  localparam int BYTES  = DATA_W / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [COL_W-1:0] reqCol = '0;
  logic [MAX_BL*DATA_W-1:0] reqWrData = '0;
  logic [MAX_BL*BYTES-1:0] reqWrMask = '0;
  logic [2:0] cfgCasLat = 3'd3;
  logic cfgBurst8 = 1'b0;
  logic memCsN, memRasN, memCasN, memWeN;
  logic [COL_W-1:0] memAddr;
  logic [DATA_W-1:0] memDqOut;
  logic memDqOe;
  logic [BYTES-1:0] memDqm;
  logic [DATA_W-1:0] memDqIn = '0;
  logic rdValid;
  logic [DATA_W-1:0] rdData;
  logic done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  col_cmd_seq i_col_cmd_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqCol(reqCol), .reqWrData(reqWrData),
    .reqWrMask(reqWrMask), .cfgCasLat(cfgCasLat), .cfgBurst8(cfgBurst8),
    .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqm(memDqm),
    .memDqIn(memDqIn), .rdValid(rdValid), .rdData(rdData), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] rdPat(input logic [31:0] seed, input int b);
    return seed + 32'(b) * 32'h1111_0000 + 32'd1;
  endfunction

  // R1: idle state after reset
  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reset csN", 64'(memCsN), 64'd1);
    chk("R1", "reset rasN", 64'(memRasN), 64'd1);
    chk("R1", "reset casN", 64'(memCasN), 64'd1);
    chk("R1", "reset weN", 64'(memWeN), 64'd1);
    chk("R9", "reset ready", 64'(reqReady), 64'd1);
    chk("R10", "reset done", 64'(done), 64'd0);
    chk("R5", "reset oe", 64'(memDqOe), 64'd0);
    chk("R6", "reset dqm", 64'(memDqm), 64'd0);
    chk("R4", "reset rdValid", 64'(rdValid), 64'd0);
  endtask

  // One burst, checked on every cycle from the command to two cycles past the last beat.
  task automatic runBurst(input bit wr, input logic [2:0] cl, input bit b8,
                          input logic [COL_W-1:0] col, input logic [31:0] seed,
                          input bit disturb);
    int ecl, lat, bl;
    ecl = (cl < 3) ? 3 : (cl > 6) ? 6 : int'(cl);
    lat = wr ? ecl - 1 : ecl;
    bl  = b8 ? 8 : 4;
    @(negedge clk);
    chk("R9", "ready before request", 64'(reqReady), 64'd1);
    reqWrite  = wr;
    reqCol    = col;
    cfgCasLat = cl;
    cfgBurst8 = b8;
    for (int b = 0; b < MAX_BL; b++) begin
      reqWrData[b*DATA_W +: DATA_W] = seed ^ (32'(b) * 32'h0101_0101);
      reqWrMask[b*BYTES +: BYTES]   = BYTES'(seed[7:4] ^ 4'(b));
    end
    reqValid = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= lat + bl + 1; k++) begin
      bit oeExp, rvExp;
      @(negedge clk);
      if (k == 0 && !disturb) reqValid = 1'b0;
      if (k == 1 && disturb) begin
        // R8 and R9: config changes and extra requests mid-burst
        cfgCasLat = 3'(~cl);
        cfgBurst8 = !b8;
        reqWrite  = !wr;
        reqCol    = ~col;
      end
      if (k == lat + bl - 1) reqValid = 1'b0;
      chk("R1", $sformatf("csN k=%0d", k), 64'(memCsN), 64'(k != 0));
      chk("R1", $sformatf("rasN k=%0d", k), 64'(memRasN), 64'd1);
      if (wr) begin
        chk("R3", $sformatf("casN k=%0d", k), 64'(memCasN), 64'(k != 0));
        chk("R3", $sformatf("weN k=%0d", k), 64'(memWeN), 64'(k != 0));
      end else begin
        chk("R2", $sformatf("casN k=%0d", k), 64'(memCasN), 64'(k != 0));
        chk("R2", $sformatf("weN k=%0d", k), 64'(memWeN), 64'd1);
      end
      chk("R2", $sformatf("addr k=%0d", k), 64'(memAddr), (k == 0) ? 64'(col) : 64'd0);
      oeExp = wr && k >= lat && k < lat + bl;
      chk("R5", $sformatf("oe k=%0d", k), 64'(memDqOe), 64'(oeExp));
      if (oeExp) begin
        chk("R7", $sformatf("dq beat %0d", k - lat), 64'(memDqOut),
            64'(seed ^ (32'(k - lat) * 32'h0101_0101)));
        chk("R6", $sformatf("dqm beat %0d", k - lat), 64'(memDqm),
            64'(BYTES'(seed[7:4] ^ 4'(k - lat))));
      end else begin
        chk("R6", $sformatf("dqm quiet k=%0d", k), 64'(memDqm), 64'd0);
      end
      rvExp = !wr && k - 1 >= lat && k - 1 < lat + bl;
      chk("R4", $sformatf("rdValid k=%0d", k), 64'(rdValid), 64'(rvExp));
      if (rvExp)
        chk("R4", $sformatf("rdData beat %0d", k - 1 - lat), 64'(rdData),
            64'(rdPat(seed, k - 1 - lat)));
      chk("R10", $sformatf("done k=%0d", k), 64'(done), 64'(k == lat + bl));
      chk("R9", $sformatf("ready k=%0d", k), 64'(reqReady), 64'(k >= lat + bl));
      if (!wr && k >= lat && k < lat + bl) memDqIn = rdPat(seed, k - lat);
      else memDqIn = 32'hBAD0_0000 | 32'(k);
    end
    reqValid = 1'b0;
  endtask

  task automatic testReadCl3Bl8();  runBurst(1'b0, 3'd3, 1'b1, 10'h155, 32'hA5A5_0010, 1'b0); endtask
  task automatic testWriteCl3Bl4(); runBurst(1'b1, 3'd3, 1'b0, 10'h0F3, 32'h1234_5670, 1'b0); endtask
  task automatic testReadCl6Bl4();  runBurst(1'b0, 3'd6, 1'b0, 10'h3FF, 32'h0BAD_F00D, 1'b0); endtask
  task automatic testWriteCl5Bl8(); runBurst(1'b1, 3'd5, 1'b1, 10'h001, 32'hCAFE_00E0, 1'b0); endtask
  // R8: clamping of out-of-range latency
  task automatic testReadClampLow();   runBurst(1'b0, 3'd1, 1'b0, 10'h222, 32'h7777_0030, 1'b0); endtask
  task automatic testWriteClampHigh(); runBurst(1'b1, 3'd7, 1'b1, 10'h111, 32'h5555_00C0, 1'b0); endtask
  // R8 and R9: disturbance during the burst is ignored
  task automatic testReadDisturb();  runBurst(1'b0, 3'd4, 1'b0, 10'h2AA, 32'h3141_5920, 1'b1); endtask
  task automatic testWriteDisturb(); runBurst(1'b1, 3'd4, 1'b1, 10'h0AA, 32'h2718_2890, 1'b1); endtask

  initial begin
    testReset();
    testReadCl3Bl8();
    testWriteCl3Bl4();
    testReadCl6Bl4();
    testWriteCl5Bl8();
    testReadClampLow();
    testWriteClampHigh();
    testReadDisturb();
    testWriteDisturb();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule